// File: doc/BRIEF.md
# Strap-Selected Triple-Redundant Configuration Loader

This block brings a device up after power-on reset. On the first clock after reset is released it latches three strap pins into a profile number. After a fixed settling delay it reads the chosen profile from an external byte-wide non-volatile store three times in a row. It merges the three copies bit by bit with a 2-of-3 majority vote into an internal register file, so a single corrupted copy of any bit cannot reach the device settings.

As soon as the first copy has been fetched, the block puts the device into Standby and switches on the internal regulators and the reference oscillator. The activation bit in that copy is not consulted. Once the third copy has been voted, the register file is final and a done flag rises. The power mode then follows the voted activation bit: Run when it is set, Standby when it is clear. A register write port exists for use after loading. Any write attempted before the load completes is refused and leaves the register file untouched. Pulling reset low at any time abandons the load.

Top module: `cfg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pwr_mode` = 2'b00 (off), `regu_en` = 0, `osc_en` = 0, `load_done` = 0, `mem_req` = 0, and the register file reads as all zero.
- R2: The profile number is {`strap_tx`, `strap_rx`, `strap_en`} (tx is bit 2, en is bit 0), sampled at the first clock edge with `rst_n` high. Strap changes after that edge have no effect on the addresses read.
- R3: `mem_req` first goes high exactly STARTUP_CYCLES + 1 clock edges after the edge at which reset is seen released.
- R4: Each request presents `mem_addr` = ((profile × 3 + copy) × PROF_BYTES + byte), where copy is 0, 1 or 2. The address is held until `mem_valid` is sampled high together with `mem_req`, and exactly one byte is taken per such cycle.
- R5: The three copies are fetched in the order 0, 1, 2, each from byte 0 upward, and `mem_req` stays high without a gap from the first byte of copy 0 to the last byte of copy 2.
- R6: From the cycle after the last byte of copy 0 is taken, `pwr_mode` is at least Standby (2'b01) and `regu_en` and `osc_en` are 1, whatever the stored activation bit is.
- R7: After loading, each register byte equals the bitwise 2-of-3 majority of the same byte in the three copies.
- R8: `load_done` rises in the cycle after the last byte of copy 2 is taken, and not earlier. `mem_req` is low from that cycle on, and `load_done` stays high until reset.
- R9: After loading, `pwr_mode` is Run (2'b10) when bit 6 of register 0x0A is 1, and Standby (2'b01) when it is 0. Run never appears before `load_done`.
- R10: A write (`reg_wr_en` high at an edge) made before `load_done` is high at that edge gives a one-cycle `reg_wr_rej` pulse and changes no register. This includes a write in the same edge as the final voted byte. A write made after that gives a one-cycle `reg_wr_ack` pulse and updates the register, and the power mode then follows a newly written activation bit.
- R11: Reset asserted in the middle of a load abandons it. After release, a fresh load starts with newly sampled straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts a load |
| strap_tx | input | 1 | Profile select strap, bit 2 |
| strap_rx | input | 1 | Profile select strap, bit 1 |
| strap_en | input | 1 | Profile select strap, bit 0 |
| mem_req | output | 1 | Read request to the configuration store |
| mem_addr | output | ADDR_W | Byte address of the current request |
| mem_valid | input | 1 | Read data valid; one byte per pulse |
| mem_rdata | input | 8 | Read data byte |
| reg_rd_addr | input | IDX_W | Register file read index |
| reg_rd_data | output | 8 | Register file read data (combinational) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | IDX_W | Register write index |
| reg_wr_data | input | 8 | Register write data |
| reg_wr_ack | output | 1 | Write accepted (one cycle after the strobe) |
| reg_wr_rej | output | 1 | Write refused during loading (one cycle after the strobe) |
| pwr_mode | output | 2 | 00 off, 01 Standby, 10 Run |
| regu_en | output | 1 | Internal regulator enable |
| osc_en | output | 1 | Reference oscillator enable |
| load_done | output | 1 | Register file is final |

## Verification
The delicate overlap is a register write that arrives on the same clock edge as the final voted byte of copy 2. Loading finishes on that edge, yet the write must still be refused and the voted value must survive. The bench waits until the memory model is presenting the last byte of the third copy and raises the write strobe for that same edge. It then expects a reject pulse together with the rising done flag, and it later reads the target register back against the vote. A second overlap, reset falling in the middle of copy 1, is judged by the full return to the reset outputs and by the addresses of the fresh load.

// File: rtl/cfg_pkg.sv
// Shared types and constants for the configuration loader.
// Assumes: register 0x0A carries the activation and enable bits.
package cfg_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_LOAD = 2'b10,
        ST_DONE = 2'b11
    } ld_state_t;

    // Power mode codes driven on pwr_mode
    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_STBY = 2'b01;
    localparam logic [1:0] MODE_RUN  = 2'b10;

    localparam int unsigned NUM_COPIES = 3;
    localparam int unsigned STRAP_W    = 3;
    localparam int unsigned CTRL_REG   = 10;   // register holding enable/activation
    localparam int unsigned ACT_BIT    = 6;
    localparam int unsigned ENB_BIT    = 7;

    // Bitwise 2-of-3 majority of three bytes
    function automatic logic [7:0] maj3(input logic [7:0] a,
                                        input logic [7:0] b,
                                        input logic [7:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cfg_seq.sv
// Load sequencer: latches the strap profile, waits the settling delay,
// then walks copy 0..2 and byte 0..PROF_BYTES-1 with a req/valid read.
// Assumes: mem_valid is only meaningful while mem_req is high.
module cfg_seq
    import cfg_pkg::*;
#(
    parameter int unsigned PROF_BYTES     = 16,
    parameter int unsigned STARTUP_CYCLES = 1055,
    parameter int unsigned ADDR_W         = 9,
    parameter int unsigned IDX_W          = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STRAP_W-1:0]  straps,
    input  logic                mem_valid,
    output ld_state_t           state,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          copy_idx,
    output logic [IDX_W-1:0]    byte_idx,
    output logic                byte_take,
    output logic                stby_flag
);

    localparam int unsigned CNT_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] WAIT_END = CNT_W'(STARTUP_CYCLES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PROF_BYTES - 1);
    localparam logic [1:0]       LAST_CPY = 2'(NUM_COPIES - 1);

    logic [STRAP_W-1:0] prof_q;
    logic [CNT_W-1:0]   wait_cnt;
    logic [ADDR_W-1:0]  slot;
    logic               last_byte;

    // Request is live for the whole fetch phase
    assign mem_req   = (state == ST_LOAD);
    assign byte_take = mem_req & mem_valid;
    assign last_byte = (byte_idx == LAST_IDX);

    // Address of the current byte from profile, copy and byte index
    always_comb begin
        slot     = ADDR_W'(prof_q) * ADDR_W'(NUM_COPIES) + ADDR_W'(copy_idx);
        mem_addr = slot * ADDR_W'(PROF_BYTES) + ADDR_W'(byte_idx);
    end

    // Phase, counters and strap latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            prof_q   <= '0;
            wait_cnt <= '0;
            copy_idx <= '0;
            byte_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    prof_q   <= straps;
                    wait_cnt <= '0;
                    state    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (wait_cnt == WAIT_END) begin
                        state    <= ST_LOAD;
                        copy_idx <= '0;
                        byte_idx <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (mem_valid) begin
                        if (last_byte) begin
                            byte_idx <= '0;
                            if (copy_idx == LAST_CPY) begin
                                state <= ST_DONE;
                            end else begin
                                copy_idx <= copy_idx + 1'b1;
                            end
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    // Standby latch: set once the first copy is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_flag <= 1'b0;
        end else if (byte_take && last_byte && copy_idx == 2'd0) begin
            stby_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_copy_buf.sv
// Holding store for copies 0 and 1; copy 2 is voted on arrival and
// never stored. Assumes byte_take pulses once per fetched byte.
module cfg_copy_buf #(
    parameter int unsigned PROF_BYTES = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_take,
    input  logic [1:0]              copy_idx,
    input  logic [IDX_W-1:0]        byte_idx,
    input  logic [7:0]              rdata,
    output logic [PROF_BYTES*8-1:0] copy_a,
    output logic [PROF_BYTES*8-1:0] copy_b
);

    generate
        for (genvar g = 0; g < PROF_BYTES; g++) begin : g_slot
            logic hit;
            assign hit = byte_take && (byte_idx == IDX_W'(g));

            // Capture this byte slot for copy 0 or copy 1
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    copy_a[g*8 +: 8] <= 8'h00;
                    copy_b[g*8 +: 8] <= 8'h00;
                end else if (hit && copy_idx == 2'd0) begin
                    copy_a[g*8 +: 8] <= rdata;
                end else if (hit && copy_idx == 2'd1) begin
                    copy_b[g*8 +: 8] <= rdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_vote_rf.sv
// Voted register file: third-copy bytes are merged with the two held
// copies by 2-of-3 majority; a write port works only once loading ends.
// Assumes vote_take and wr_allow are never high together.
module cfg_vote_rf
    import cfg_pkg::*;
#(
    parameter int unsigned PROF_BYTES = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vote_take,
    input  logic [IDX_W-1:0]        byte_idx,
    input  logic [7:0]              rdata,
    input  logic [PROF_BYTES*8-1:0] copy_a,
    input  logic [PROF_BYTES*8-1:0] copy_b,
    input  logic                    wr_allow,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [IDX_W-1:0]        rd_addr,
    output logic [7:0]              rd_data,
    output logic                    act_bit,
    output logic                    wr_ack,
    output logic                    wr_rej
);

    logic [7:0] rf [PROF_BYTES];

    generate
        for (genvar g = 0; g < PROF_BYTES; g++) begin : g_reg
            logic vote_hit;
            logic wr_hit;
            assign vote_hit = vote_take && (byte_idx == IDX_W'(g));
            assign wr_hit   = wr_allow && wr_en && (wr_addr == IDX_W'(g));

            // Load the voted byte, or a post-load write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rf[g] <= 8'h00;
                end else if (vote_hit) begin
                    rf[g] <= maj3(copy_a[g*8 +: 8], copy_b[g*8 +: 8], rdata);
                end else if (wr_hit) begin
                    rf[g] <= wr_data;
                end
            end
        end
    endgenerate

    // Combinational read with out-of-range guard
    always_comb begin
        if (int'(rd_addr) < PROF_BYTES) rd_data = rf[rd_addr];
        else                            rd_data = 8'h00;
    end

    assign act_bit = rf[CTRL_REG][ACT_BIT];

    // Write outcome pulses, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack <= 1'b0;
            wr_rej <= 1'b0;
        end else begin
            wr_ack <= wr_en && wr_allow;
            wr_rej <= wr_en && !wr_allow;
        end
    end

endmodule

// File: rtl/cfg_loader.sv
// Top of the strap-selected, triple-read configuration loader.
// Forces Standby after the first copy; picks Run/Standby from the voted
// activation bit once loading ends. Assumes PROF_BYTES > CTRL_REG.
module cfg_loader
    import cfg_pkg::*;
#(
    parameter int unsigned PROF_BYTES     = 16,
    parameter int unsigned STARTUP_CYCLES = 1055,
    localparam int unsigned ADDR_W = $clog2((1 << STRAP_W) * NUM_COPIES * PROF_BYTES),
    localparam int unsigned IDX_W  = $clog2(PROF_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_tx,
    input  logic              strap_rx,
    input  logic              strap_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [7:0]        mem_rdata,
    input  logic [IDX_W-1:0]  reg_rd_addr,
    output logic [7:0]        reg_rd_data,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    output logic              reg_wr_ack,
    output logic              reg_wr_rej,
    output logic [1:0]        pwr_mode,
    output logic              regu_en,
    output logic              osc_en,
    output logic              load_done
);

    ld_state_t              state;
    logic [1:0]             copy_idx;
    logic [IDX_W-1:0]       byte_idx;
    logic                   byte_take;
    logic                   stby_flag;
    logic                   act_bit;
    logic [PROF_BYTES*8-1:0] copy_a;
    logic [PROF_BYTES*8-1:0] copy_b;

    cfg_seq #(
        .PROF_BYTES     (PROF_BYTES),
        .STARTUP_CYCLES (STARTUP_CYCLES),
        .ADDR_W         (ADDR_W),
        .IDX_W          (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .straps    ({strap_tx, strap_rx, strap_en}),
        .mem_valid (mem_valid),
        .state     (state),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .copy_idx  (copy_idx),
        .byte_idx  (byte_idx),
        .byte_take (byte_take),
        .stby_flag (stby_flag)
    );

    cfg_copy_buf #(
        .PROF_BYTES (PROF_BYTES),
        .IDX_W      (IDX_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_take (byte_take),
        .copy_idx  (copy_idx),
        .byte_idx  (byte_idx),
        .rdata     (mem_rdata),
        .copy_a    (copy_a),
        .copy_b    (copy_b)
    );

    cfg_vote_rf #(
        .PROF_BYTES (PROF_BYTES),
        .IDX_W      (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .vote_take (byte_take && copy_idx == 2'd2),
        .byte_idx  (byte_idx),
        .rdata     (mem_rdata),
        .copy_a    (copy_a),
        .copy_b    (copy_b),
        .wr_allow  (state == ST_DONE),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_addr   (reg_rd_addr),
        .rd_data   (reg_rd_data),
        .act_bit   (act_bit),
        .wr_ack    (reg_wr_ack),
        .wr_rej    (reg_wr_rej)
    );

    assign load_done = (state == ST_DONE);
    assign regu_en   = stby_flag;
    assign osc_en    = stby_flag;

    // Power mode: off until copy 0 is in, then Standby, Run once voted act=1
    always_comb begin
        if (!stby_flag)                pwr_mode = MODE_OFF;
        else if (load_done && act_bit) pwr_mode = MODE_RUN;
        else                           pwr_mode = MODE_STBY;
    end

endmodule

// File: rtl/cfg_loader_chk.sv
// Protocol and mode checks for cfg_loader, attached by bind.
module cfg_loader_chk #(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_wr_ack,
    input logic              reg_wr_rej,
    input logic [1:0]        pwr_mode,
    input logic              regu_en,
    input logic              osc_en,
    input logic              load_done
);

    AST_RESET_OUTPUTS: assert property (@(posedge clk) !rst_n |=> (pwr_mode == 2'b00 && !load_done && !mem_req && !regu_en)); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R4
    AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) load_done |-> !mem_req); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) load_done |=> load_done); // R8
    AST_POWER_WITH_MODE: assert property (@(posedge clk) disable iff (!rst_n) (pwr_mode != 2'b00) |-> (regu_en && osc_en)); // R6
    AST_RUN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) (pwr_mode == 2'b10) |-> load_done); // R9
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) pwr_mode != 2'b11); // R9
    AST_ACK_ONLY_LOADED: assert property (@(posedge clk) disable iff (!rst_n) reg_wr_ack |-> load_done); // R10
    AST_ACK_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({reg_wr_ack, reg_wr_rej})); // R10

endmodule

bind cfg_loader cfg_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .reg_wr_ack (reg_wr_ack),
    .reg_wr_rej (reg_wr_rej),
    .pwr_mode   (pwr_mode),
    .regu_en    (regu_en),
    .osc_en     (osc_en),
    .load_done  (load_done)
);

// File: tb/sim_cfg_loader.sv
// Bench: behavioural reference model (byte queue, integer phase) compared
// with the loader outputs on every falling clock edge.
module sim_cfg_loader;

    localparam int PB  = 16;
    localparam int DLY = 20;
    localparam int AW  = $clog2(8 * 3 * PB);
    localparam int IW  = $clog2(PB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_tx = 1'b0, strap_rx = 1'b0, strap_en = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [7:0]    mem_rdata = 8'h00;
    logic [IW-1:0] reg_rd_addr = '0;
    logic [7:0]    reg_rd_data;
    logic          reg_wr_en = 1'b0;
    logic [IW-1:0] reg_wr_addr = '0;
    logic [7:0]    reg_wr_data = 8'h00;
    logic          reg_wr_ack, reg_wr_rej;
    logic [1:0]    pwr_mode;
    logic          regu_en, osc_en, load_done;

    always #5 clk = ~clk;

    cfg_loader #(.PROF_BYTES(PB), .STARTUP_CYCLES(DLY)) u0 (.*);

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [8*3*PB];
    int lat = 1;
    int lcnt = 0;

    always @(negedge clk) begin
        if (!rst_n || mem_valid) begin
            mem_valid <= 1'b0;
            lcnt <= 0;
        end else if (mem_req) begin
            if (lcnt >= lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem[mem_addr];
            end else begin
                lcnt <= lcnt + 1;
            end
        end
    end

    // ---------------- reference model ----------------
    int         m_phase = 0;   // 0 idle, 1 settling, 2 fetching, 3 loaded
    int         m_wait = 0;
    int         m_prof = 0;
    logic [7:0] q[$];
    logic [7:0] m_regs [PB];
    bit         m_ack = 0, m_rej = 0;
    bit         started = 0;

    function automatic logic [7:0] vote(input logic [7:0] a, b, c);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = (int'(a[k]) + int'(b[k]) + int'(c[k])) >= 2;
        return r;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_phase = 0;
            q.delete();
            m_ack = 0;
            m_rej = 0;
            for (int i = 0; i < PB; i++) m_regs[i] = 8'h00;
        end else begin
            m_ack = reg_wr_en && (m_phase == 3);
            m_rej = reg_wr_en && (m_phase != 3);
            if (m_ack) m_regs[reg_wr_addr] = reg_wr_data;
            case (m_phase)
                0: begin m_prof = {strap_tx, strap_rx, strap_en}; m_wait = 0; m_phase = 1; end
                1: if (m_wait == DLY - 1) m_phase = 2; else m_wait++;
                2: if (mem_valid) begin
                       q.push_back(mem_rdata);
                       if (q.size() == 3 * PB) begin
                           for (int i = 0; i < PB; i++) m_regs[i] = vote(q[i], q[PB+i], q[2*PB+i]);
                           m_phase = 3;
                       end
                   end
                default: ;
            endcase
        end
    end

    // Every-cycle comparison
    always @(negedge clk) begin
        if (started) begin
            bit e_req, e_sb, e_done;
            int e_mode, e_addr;
            e_req  = (m_phase == 2);
            e_sb   = (m_phase >= 2) && (q.size() >= PB);
            e_done = (m_phase == 3);
            e_mode = !e_sb ? 0 : (e_done && m_regs[10][6]) ? 2 : 1;
            e_addr = m_prof * 3 * PB + q.size();
            chk(mem_req == e_req, "R3/R5 mem_req", mem_req, e_req);
            if (e_req) chk(int'(mem_addr) == e_addr, "R4 mem_addr", mem_addr, e_addr);
            chk(regu_en == e_sb && osc_en == e_sb, "R6 enables", {regu_en, osc_en}, {e_sb, e_sb});
            chk(load_done == e_done, "R8 load_done", load_done, e_done);
            chk(int'(pwr_mode) == e_mode, "R9 pwr_mode", pwr_mode, e_mode);
            chk(reg_wr_ack == m_ack && reg_wr_rej == m_rej, "R10 ack/rej",
                {reg_wr_ack, reg_wr_rej}, {m_ack, m_rej});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset(input int n, input bit t, input bit r, input bit e, input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        strap_tx = t; strap_rx = r; strap_en = e;
        repeat (n) @(negedge clk);
        #1;
        chk(pwr_mode == 2'b00 && !load_done && !mem_req && !regu_en && !osc_en,
            tag, {pwr_mode, load_done, mem_req, regu_en}, 0);
        reg_rd_addr = IW'(10);
        #1;
        chk(reg_rd_data == 8'h00, tag, reg_rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        while (!load_done) @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < PB; i++) begin
            @(negedge clk);
            reg_rd_addr = IW'(i);
            #1;
            chk(reg_rd_data == m_regs[i], tag, reg_rd_data, m_regs[i]);
        end
    endtask

    task automatic write_reg(input int a, input logic [7:0] d);
        @(negedge clk);
        #1;
        reg_wr_en = 1'b1; reg_wr_addr = IW'(a); reg_wr_data = d;
        @(negedge clk);
        #1;
        reg_wr_en = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int n;
        for (int a = 0; a < 8 * 3 * PB; a++) mem[a] = 8'((a * 73 + 29) ^ ((a * a) >> 2));
        // profile 5: copy 0 act clear, copies 1 and 2 act set -> voted act 1
        mem[(5*3+0)*PB + 10] = 8'h00;
        mem[(5*3+1)*PB + 10] = 8'h40;
        mem[(5*3+2)*PB + 10] = 8'hC0;
        // profile 2: copy 0 act set, copies 1 and 2 act clear -> voted act 0
        mem[(2*3+0)*PB + 10] = 8'h40;
        mem[(2*3+1)*PB + 10] = 8'h00;
        mem[(2*3+2)*PB + 10] = 8'h80;

        // Scenario 1: profile 5, latency 1
        lat = 1;
        do_reset(3, 1'b1, 1'b0, 1'b1, "R1 reset state");
        n = 0;
        while (!mem_req) begin
            @(negedge clk);
            n++;
            if (n == 3) begin strap_tx = 1'b0; strap_rx = 1'b1; strap_en = 1'b0; end
            if (n == 5) begin reg_wr_en = 1'b1; reg_wr_addr = IW'(10); reg_wr_data = 8'h00; end
            if (n == 6) begin
                reg_wr_en = 1'b0;
                chk(reg_wr_rej == 1'b1, "R10 early write rejected", reg_wr_rej, 1);
            end
        end
        chk(n == DLY + 1, "R3 request delay", n, DLY + 1);
        chk(int'(mem_addr) == 5 * 3 * PB, "R2 strap profile address", mem_addr, 5 * 3 * PB);
        // write on the same edge as the final voted byte
        forever begin
            @(negedge clk);
            #1;
            if (mem_valid && q.size() == 3 * PB - 1) break;
        end
        reg_wr_en = 1'b1; reg_wr_addr = IW'(10); reg_wr_data = 8'h00;
        @(negedge clk);
        #1;
        reg_wr_en = 1'b0;
        chk(reg_wr_rej == 1'b1 && reg_wr_ack == 1'b0, "R10 coincident write rejected",
            {reg_wr_ack, reg_wr_rej}, 1);
        chk(load_done == 1'b1, "R8 done after last byte", load_done, 1);
        chk(pwr_mode == 2'b10, "R9 run on voted act", pwr_mode, 2);
        read_all("R7 voted registers");
        write_reg(10, 8'h80);
        chk(reg_wr_ack == 1'b1, "R10 write accepted", reg_wr_ack, 1);
        chk(pwr_mode == 2'b01, "R10 mode follows written act", pwr_mode, 1);
        write_reg(3, 8'hA5);
        reg_rd_addr = IW'(3);
        #1;
        chk(reg_rd_data == 8'hA5, "R10 write readback", reg_rd_data, 8'hA5);

        // Scenario 2: profile 2, latency 3, act set only in copy 0
        lat = 3;
        do_reset(2, 1'b0, 1'b1, 1'b0, "R1 reset state again");
        while (q.size() < PB) @(negedge clk);
        #1;
        chk(pwr_mode == 2'b01 && regu_en && osc_en, "R6 standby after copy 0",
            {pwr_mode, regu_en, osc_en}, 3'b011);
        wait_done();
        #1;
        chk(pwr_mode == 2'b01, "R9 standby on voted act 0", pwr_mode, 1);
        read_all("R7 voted registers profile 2");

        // Scenario 3: abort mid copy 1, restart on profile 1, latency 0
        lat = 0;
        do_reset(2, 1'b1, 1'b1, 1'b1, "R1 reset state third");
        while (q.size() < PB + 3) @(negedge clk);
        do_reset(2, 1'b0, 1'b0, 1'b1, "R11 abort returns to reset");
        while (!mem_req) @(negedge clk);
        chk(int'(mem_addr) == 1 * 3 * PB, "R11 new profile after abort", mem_addr, 3 * PB);
        wait_done();
        read_all("R7 voted registers after abort");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule